// File: doc/BRIEF.md
# 32-bit Add/Subtract Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. Two operands and a 4-bit operation code go in. A 32-bit result comes out, together with three flags:

- a zero flag, for equal/not-equal branch decisions;
- a signed-overflow flag;
- the raw carry out of the adder's top bit.

One ripple-carry adder serves addition, subtraction and both comparisons. In subtract mode the second operand is bit-wise complemented and a carry of one is injected at bit 0. Overflow is detected as the carry into the top bit differing from the carry out of it, and it is reported only for the signed add and signed subtract codes.

The block holds no state, so it has no states or transitions to name. Results are valid one propagation delay after the inputs settle. Encoding, for every requirement below:

| Code | Operation |
|------|-----------|
| 0000 | AND |
| 0001 | OR |
| 0010 | ADD |
| 0011 | ADDU |
| 0110 | SUB |
| 0111 | SUBU |
| 1000 | SLT |
| 1001 | SLTU |
| 1100 | NOR |
| 1101 | XOR |

The adder runs in subtract mode for codes 0110, 0111, 1000 and 1001. It adds for all other codes.

Top module: `alu32_addsub`

## Requirements
- R1: Codes 0000, 0001, 1100 and 1101 return a AND b, a OR b, NOT(a OR b) and a XOR b respectively, bit by bit.
- R2: Codes 0010 (ADD) and 0011 (ADDU) return (a + b) modulo 2^32.
- R3: Codes 0110 (SUB) and 0111 (SUBU) return (a + NOT b + 1) modulo 2^32, which equals a - b.
- R4: For ADD, ovf_o is 1 exactly when a and b have equal sign bits and the result's sign bit differs from them. For SUB, ovf_o is 1 exactly when a and b have different sign bits and the result's sign bit differs from a's. Adding operands of opposite sign, or subtracting operands of equal sign, never sets ovf_o.
- R5: ovf_o is 0 for every code other than 0010 and 0110, including ADDU and SUBU, whatever the operands.
- R6: Code 1000 (SLT) returns 1 when a < b as two's-complement numbers and 0 otherwise, with bits 31..1 zero. The answer stays correct when a - b overflows.
- R7: Code 1001 (SLTU) returns 1 when a < b as unsigned numbers and 0 otherwise, with bits 31..1 zero.
- R8: zero_o is 1 exactly when all 32 result bits are 0.
- R9: carry_o is bit 32 of a + b for codes in add mode, and bit 32 of a + NOT b + 1 for the four subtract-mode codes. In subtract mode it is therefore 1 exactly when a >= b unsigned.
- R10: Any code not listed in the encoding returns result 0, with zero_o 1 and ovf_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of ADD or SUB |
| carry_o | output | 1 | Carry out of the adder's top bit |

## Verification
The bench concentrates on the overflow boundaries: 0x7FFFFFFF + 1, 0x80000000 + 0x80000000, 0x80000000 - 1 and 0 - 0x80000000. A design that took overflow from the carry out alone, or that let ADDU/SUBU raise it, would flag the wrong cases. Signed compares are driven across overflowing differences such as 0x7FFFFFFF against 0x80000000. A design that used only the sign of the difference there would invert the answer. Every one of the 16 codes is swept to catch a missing default or a swapped encoding. Equal operands under subtract confirm the zero flag and the carry for unsigned greater-or-equal, where a missing injected carry would leave the result at minus one.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
    localparam int unsigned OP_W = 4;

    localparam logic [OP_W-1:0] OP_AND  = 4'b0000;
    localparam logic [OP_W-1:0] OP_OR   = 4'b0001;
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0010;
    localparam logic [OP_W-1:0] OP_ADDU = 4'b0011;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0110;
    localparam logic [OP_W-1:0] OP_SUBU = 4'b0111;
    localparam logic [OP_W-1:0] OP_SLT  = 4'b1000;
    localparam logic [OP_W-1:0] OP_SLTU = 4'b1001;
    localparam logic [OP_W-1:0] OP_NOR  = 4'b1100;
    localparam logic [OP_W-1:0] OP_XOR  = 4'b1101;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2,
        LG_XOR = 2'd3
    } logic_fn_t;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'd0,
        SEL_LOGIC = 3'd1,
        SEL_SUM   = 3'd2,
        SEL_SLT   = 3'd3,
        SEL_SLTU  = 3'd4
    } res_sel_t;

    typedef struct packed {
        logic      sub_mode;
        logic      chk_ovf;
        res_sel_t  sel;
        logic_fn_t lfn;
    } ctrl_t;
endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
    import alu32_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output ctrl_t           ctrl_o
);
    always_comb begin
        ctrl_o = '{sub_mode: 1'b0, chk_ovf: 1'b0, sel: SEL_ZERO, lfn: LG_AND};
        unique case (op_i)
            OP_AND:  begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_AND; end
            OP_OR:   begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_OR;  end
            OP_NOR:  begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_NOR; end
            OP_XOR:  begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_XOR; end
            OP_ADD:  begin ctrl_o.sel = SEL_SUM;   ctrl_o.chk_ovf = 1'b1; end
            OP_ADDU: begin ctrl_o.sel = SEL_SUM; end
            OP_SUB:  begin ctrl_o.sel = SEL_SUM;   ctrl_o.sub_mode = 1'b1; ctrl_o.chk_ovf = 1'b1; end
            OP_SUBU: begin ctrl_o.sel = SEL_SUM;   ctrl_o.sub_mode = 1'b1; end
            OP_SLT:  begin ctrl_o.sel = SEL_SLT;   ctrl_o.sub_mode = 1'b1; end
            OP_SLTU: begin ctrl_o.sel = SEL_SLTU;  ctrl_o.sub_mode = 1'b1; end
            default: ctrl_o.sel = SEL_ZERO;
        endcase
    end
endmodule

// File: rtl/alu32_ripple_adder.sv
module alu32_ripple_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_top_in_o,
    output logic         c_out_o
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    assign b_eff    = b_i ^ {W{sub_i}};
    assign carry[0] = sub_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_eff[i]) | (a_i[i] & carry[i]) | (b_eff[i] & carry[i]);
    end

    assign c_top_in_o = carry[W-1];
    assign c_out_o    = carry[W];
endmodule

// File: rtl/alu32_logic_unit.sv
module alu32_logic_unit
    import alu32_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_fn_t    fn_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_NOR:  y_o = ~(a_i | b_i);
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu32_addsub.sv
module alu32_addsub
    import alu32_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_o,
    output logic            carry_o
);
    ctrl_t        ctrl;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic         c_top_in;
    logic         c_out;
    logic         raw_ovf;
    logic         lt_signed;
    logic         lt_unsigned;

    alu32_decode u_dec (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    alu32_ripple_adder #(.W(W)) u_add (
        .a_i        (a_i),
        .b_i        (b_i),
        .sub_i      (ctrl.sub_mode),
        .sum_o      (sum),
        .c_top_in_o (c_top_in),
        .c_out_o    (c_out)
    );

    alu32_logic_unit #(.W(W)) u_lgc (
        .a_i  (a_i),
        .b_i  (b_i),
        .fn_i (ctrl.lfn),
        .y_o  (lres)
    );

    assign raw_ovf     = c_top_in ^ c_out;
    assign lt_signed   = sum[W-1] ^ raw_ovf;
    assign lt_unsigned = ~c_out;

    always_comb begin
        unique case (ctrl.sel)
            SEL_LOGIC: result_o = lres;
            SEL_SUM:   result_o = sum;
            SEL_SLT:   result_o = {{(W-1){1'b0}}, lt_signed};
            SEL_SLTU:  result_o = {{(W-1){1'b0}}, lt_unsigned};
            default:   result_o = '0;
        endcase
    end

    assign zero_o  = ~|result_o;
    assign ovf_o   = ctrl.chk_ovf & raw_ovf;
    assign carry_o = c_out;
endmodule

// File: rtl/alu32_addsub_chk.sv
module alu32_addsub_chk
    import alu32_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    result_o,
    input logic            zero_o,
    input logic            ovf_o,
    input logic            carry_o
);
    always_comb begin
        if (op_i == OP_ADD && a_i[W-1] != b_i[W-1])
            p_no_overflow_r4: assert (ovf_o == 1'b0);
        if (op_i == OP_SUB && a_i[W-1] == b_i[W-1])
            p_sub_same_sign_r4: assert (ovf_o == 1'b0);
        if (op_i != OP_ADD && op_i != OP_SUB)
            p_ovf_masked_r5: assert (ovf_o == 1'b0);
        if (op_i == OP_SLT)
            p_slt_boolean_r6: assert (result_o[W-1:1] == '0);
        if (op_i == OP_SLTU)
            p_sltu_vs_carry_r7: assert (result_o[0] == ~carry_o && result_o[W-1:1] == '0);
        if (op_i == OP_SUB && a_i == b_i)
            p_equal_gives_zero_r8: assert (zero_o && carry_o);
        if (op_i == 4'b1111 || op_i == 4'b0100 || op_i == 4'b1010)
            p_undefined_code_r10: assert (result_o == '0 && zero_o);
    end
endmodule

bind alu32_addsub alu32_addsub_chk #(.W(W)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o),
    .carry_o  (carry_o)
);

// File: tb/alu32_addsub_tb_top.sv
`timescale 1ns/1ps
module alu32_addsub_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] a, b, res;
    logic [3:0]  op;
    logic        zf, of, cf;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alu32_addsub dut_i (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(res), .zero_o(zf), .ovf_o(of), .carry_o(cf)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h (a=%h b=%h op=%b)", tag, got, exp, a, b, op);
        end
    endtask

    // independent model from the requirements
    task automatic apply(input string tag, input logic [31:0] ta, input logic [31:0] tb_, input logic [3:0] top);
        logic [32:0] s;
        logic [31:0] er;
        logic        eo, ec, sm;
        @(negedge clk);
        a = ta; b = tb_; op = top;
        sm = (top == 4'b0110 || top == 4'b0111 || top == 4'b1000 || top == 4'b1001);
        s  = sm ? ({1'b0, ta} - {1'b0, tb_} + 33'h100000000) : ({1'b0, ta} + {1'b0, tb_});
        ec = s[32];
        eo = 1'b0;
        case (top)
            4'b0000: er = ta & tb_;
            4'b0001: er = ta | tb_;
            4'b1100: er = ~(ta | tb_);
            4'b1101: er = ta ^ tb_;
            4'b0010, 4'b0011: er = ta + tb_;
            4'b0110, 4'b0111: er = ta - tb_;
            4'b1000: er = {31'd0, $signed(ta) < $signed(tb_)};
            4'b1001: er = {31'd0, ta < tb_};
            default: er = 32'd0;
        endcase
        if (top == 4'b0010) eo = (ta[31] == tb_[31]) && (er[31] != ta[31]);
        if (top == 4'b0110) eo = (ta[31] != tb_[31]) && (er[31] != ta[31]);
        #1;
        chk({tag, " result"}, res, er);
        chk({tag, " zero R8"}, {31'd0, zf}, {31'd0, er == 32'd0});
        chk({tag, " ovf"}, {31'd0, of}, {31'd0, eo});
        chk({tag, " carry R9"}, {31'd0, cf}, {31'd0, ec});
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("reset R1 result", res, 32'd0);
        chk("reset R8 zero", {31'd0, zf}, 32'd1);
        chk("reset R5 ovf", {31'd0, of}, 32'd0);
    endtask

    task automatic t_logic;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] c;
            c = (k == 0) ? 4'b0000 : (k == 1) ? 4'b0001 : (k == 2) ? 4'b1100 : 4'b1101;
            apply("R1 logic", 32'hF0F0_1234, 32'h0FF0_FF00, c);
            apply("R1 logic ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, c);
        end
    endtask

    task automatic t_add;
        apply("R2 add", 32'd5, 32'd7, 4'b0010);
        apply("R4 add max+1", 32'h7FFF_FFFF, 32'd1, 4'b0010);
        apply("R4 add min+min", 32'h8000_0000, 32'h8000_0000, 4'b0010);
        apply("R4 add mixed", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
        apply("R5 addu max+1", 32'h7FFF_FFFF, 32'd1, 4'b0011);
        apply("R2 addu wrap", 32'hFFFF_FFFF, 32'd1, 4'b0011);
    endtask

    task automatic t_sub;
        apply("R3 sub", 32'd7, 32'd2, 4'b0110);
        apply("R3 sub equal", 32'h1234_5678, 32'h1234_5678, 4'b0110);
        apply("R4 sub min-1", 32'h8000_0000, 32'd1, 4'b0110);
        apply("R4 sub 0-min", 32'd0, 32'h8000_0000, 4'b0110);
        apply("R4 sub same sign", 32'hFFFF_FFFE, 32'h8000_0000, 4'b0110);
        apply("R5 subu min-1", 32'h8000_0000, 32'd1, 4'b0111);
        apply("R3 subu borrow", 32'd2, 32'd7, 4'b0111);
    endtask

    task automatic t_cmp;
        apply("R6 slt neg<pos", 32'h8000_0000, 32'd1, 4'b1000);
        apply("R6 slt ovf case", 32'h7FFF_FFFF, 32'h8000_0000, 4'b1000);
        apply("R6 slt equal", 32'd9, 32'd9, 4'b1000);
        apply("R6 slt small", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b1000);
        apply("R7 sltu", 32'h7FFF_FFFF, 32'h8000_0000, 4'b1001);
        apply("R7 sltu big", 32'hFFFF_FFFF, 32'd0, 4'b1001);
        apply("R7 sltu equal", 32'd3, 32'd3, 4'b1001);
    endtask

    task automatic t_all_codes;
        for (int c = 0; c < 16; c++)
            apply("R10 sweep", 32'hDEAD_BEEF, 32'h8765_4321, c[3:0]);
    endtask

    initial begin
        a = '0; b = '0; op = 4'b0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_cmp();
        t_all_codes();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule